// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core event counting block. One free-running cycle counter and a configurable number (1 to 31) of 32-bit event counters observe a bus of single-cycle event pulses and the processor's current privilege level (0 to 3). Each event counter is bound to one event number through its own type register. It can be told to ignore activity at levels 0 and 1, and it counts level 2 only when asked to. The cycle counter can run at the full clock rate or at one sixty-fourth of it.

Software reaches the unit through a plain single-cycle register port. Writes take effect at the next rising clock edge, and reads return data combinationally for the presented address. No port carries streamed data, so there is no valid/ready handshake. The register port never stalls, and the event bus is sampled every cycle. Enables and interrupt enables are changed through separate set and clear addresses. Overflow flags are cleared by writing ones. An event counter is addressed indirectly: software first writes its index to a select register. All overflow sources share one level-sensitive interrupt line.

Register addresses: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow status, 6 select, 7 selected count, 8 selected type, 9 cycle count, 10 software increment. In the enable, interrupt-enable, overflow and software-increment registers, bit k stands for event counter k and bit 31 stands for the cycle counter.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every counter, enable, interrupt enable, overflow flag, type and select register is zero, irq is low, and the control register (address 0) reads only the counter count N in bits 15:11.
- R2: Control bits 0 (global enable), 3 (divide cycle counter by 64), 4 and 5 hold the written value. Bits 1 and 2 read as zero. Bits 15:11 always read N, and all other bits read zero.
- R3: Writing control with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter and its prescaler.
- R4: While global enable and enable bit 31 are set, the cycle counter (address 9, writable) advances by one every clock, or once every 64 clocks when control bit 3 is set.
- R5: Writing ones to address 1 or 3 sets the matching enable or interrupt-enable bits, and writing ones to address 2 or 4 clears them. Zero bits leave a bit unchanged. Both addresses of a pair read the current mask, and bits N to 30 always read zero.
- R6: The select register (address 6) chooses counter k for the count (7) and type (8) registers. A select value of N or more makes them read zero, and writes to them are then ignored.
- R7: Only the bits under mask 0xC80003FF of a type register are stored. Bits 9:0 are the event number.
- R8: An enabled event counter adds one in each cycle in which event-bus bit [event number] is high. Event number 0x11 counts every clock. Numbers at or beyond the bus width never count.
- R9: Type bit 30 blocks counting at level 0, and bit 31 blocks counting at level 1. Level 2 counts only when bit 27 is set. Level 3 always counts.
- R10: For a counter whose event number is 0, writing a one to its bit at address 10 adds one, subject to the enables and level filter. Counters with other event numbers ignore that write.
- R11: A counter stepping from 0xFFFFFFFF to 0 sets its overflow flag (address 5). Writing ones there clears the flags, zero bits leave flags unchanged, and a new overflow in the same cycle wins over a clear.
- R12: irq is high exactly while some overflow flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_bus | input | NUM_EVENTS | Event pulses, bit i is event number i |
| el | input | 2 | Current privilege level |
| irq | output | 1 | Shared overflow interrupt, level |

## Verification
On every cycle, the assertions check that a counter without permission to count keeps its value, that a wrap lands on zero, that a counter clear empties the counter, that the prescaler holds the cycle counter between ticks, that overflow flags only fall through a clear write, and that a set write never drops an enable. The following can only be shown by the bench scenarios: exact counts under event patterns, the 64-cycle divide, the privilege filter at each level, out-of-range selection, the software increment, the read-back masks of the control and type registers, and the irq response to enable and clear writes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_EN_SET = 4'd1;
  localparam logic [3:0] A_EN_CLR = 4'd2;
  localparam logic [3:0] A_IE_SET = 4'd3;
  localparam logic [3:0] A_IE_CLR = 4'd4;
  localparam logic [3:0] A_OVF    = 4'd5;
  localparam logic [3:0] A_SEL    = 4'd6;
  localparam logic [3:0] A_EVCNT  = 4'd7;
  localparam logic [3:0] A_EVTYPE = 4'd8;
  localparam logic [3:0] A_CYCCNT = 4'd9;
  localparam logic [3:0] A_SWINC  = 4'd10;

  localparam logic [31:0] TYPE_MASK = 32'hC800_03FF;
  localparam int          NO_L1_BIT = 31;
  localparam int          NO_L0_BIT = 30;
  localparam int          L2_ON_BIT = 27;
  localparam logic [9:0]  EV_CYCLES = 10'h011;
  localparam logic [9:0]  EV_SOFT   = 10'h000;
  localparam logic [5:0]  CTRL_KEEP = 6'b111001;
  localparam int          CYC_BIT   = 31;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVENTS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [NUM_EVENTS-1:0] evt_bus,
  input  logic [1:0]            el,
  input  logic                  sw_inc,
  input  logic                  clr,
  input  logic                  wr_cnt,
  input  logic                  wr_type,
  input  logic [31:0]           wdata,
  output logic [31:0]           count_q,
  output logic [31:0]           type_q,
  output logic                  wrap
);
  logic [9:0] evnum;
  logic       bus_bit;
  logic       hit;
  logic       allow;
  logic       inc;

  assign evnum = type_q[9:0];

  always_comb begin
    bus_bit = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++)
      if (evnum == 10'(i)) bus_bit = evt_bus[i];
  end

  always_comb begin
    if (evnum == EV_CYCLES)     hit = 1'b1;
    else if (evnum == EV_SOFT)  hit = sw_inc;
    else                        hit = bus_bit;
  end

  always_comb begin
    case (el)
      2'd0:    allow = !type_q[NO_L0_BIT];
      2'd1:    allow = !type_q[NO_L1_BIT];
      2'd2:    allow = type_q[L2_ON_BIT];
      default: allow = 1'b1;
    endcase
  end

  assign inc  = run && hit && allow;
  assign wrap = inc && !clr && !wr_cnt && (count_q == 32'hFFFF_FFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      type_q  <= '0;
    end else begin
      if (clr)         count_q <= '0;
      else if (wr_cnt) count_q <= wdata;
      else if (inc)    count_q <= count_q + 32'd1;
      if (wr_type)     type_q  <= wdata & TYPE_MASK;
    end
  end

  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr_cnt) |=> $stable(count_q));
  a_r11_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_q == 32'd0));
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == 32'd0));
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int PRESCALE = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        div_en,
  input  logic        clr,
  input  logic        wr_cnt,
  input  logic [31:0] wdata,
  output logic [31:0] count_q,
  output logic        wrap
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] presc_q;
  logic          tick;
  logic          inc;

  assign tick = !div_en || (presc_q == PRE_LAST);
  assign inc  = run && tick;
  assign wrap = inc && !clr && !wr_cnt && (count_q == 32'hFFFF_FFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      count_q <= '0;
    end else begin
      if (clr)                 presc_q <= '0;
      else if (run && div_en)  presc_q <= (presc_q == PRE_LAST) ? '0 : presc_q + 1'b1;
      if (clr)                 count_q <= '0;
      else if (wr_cnt)         count_q <= wdata;
      else if (inc)            count_q <= count_q + 32'd1;
    end
  end

  a_r4_prescale_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && presc_q != PRE_LAST && !clr && !wr_cnt) |=> $stable(count_q));
  a_r11_cyc_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_q == 32'd0));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT    = 4,
  parameter int NUM_EVENTS = 32,
  parameter int PRESCALE   = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [3:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_EVENTS-1:0] evt_bus,
  input  logic [1:0]            el,
  output logic                  irq
);
  localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'h1 << NUM_CNT) - 32'h1);

  logic [5:0]  ctrl_q;
  logic [31:0] cnt_en_q, irq_en_q, ovf_q;
  logic [4:0]  sel_q;

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
  logic wr_ovf, wr_sel, wr_evcnt, wr_evtype, wr_cyc, wr_swinc;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_en_set = reg_wr && (reg_addr == A_EN_SET);
  assign wr_en_clr = reg_wr && (reg_addr == A_EN_CLR);
  assign wr_ie_set = reg_wr && (reg_addr == A_IE_SET);
  assign wr_ie_clr = reg_wr && (reg_addr == A_IE_CLR);
  assign wr_ovf    = reg_wr && (reg_addr == A_OVF);
  assign wr_sel    = reg_wr && (reg_addr == A_SEL);
  assign wr_evcnt  = reg_wr && (reg_addr == A_EVCNT);
  assign wr_evtype = reg_wr && (reg_addr == A_EVTYPE);
  assign wr_cyc    = reg_wr && (reg_addr == A_CYCCNT);
  assign wr_swinc  = reg_wr && (reg_addr == A_SWINC);

  logic [31:0]  evt_count [NUM_CNT];
  logic [31:0]  evt_type  [NUM_CNT];
  logic [NUM_CNT-1:0] evt_wrap;
  logic [31:0]  cyc_count;
  logic         cyc_wrap;
  logic [31:0]  wrap_vec;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    pmu_event_counter #(.NUM_EVENTS(NUM_EVENTS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q[0] && cnt_en_q[g]),
      .evt_bus (evt_bus),
      .el      (el),
      .sw_inc  (wr_swinc && reg_wdata[g]),
      .clr     (wr_ctrl && reg_wdata[1]),
      .wr_cnt  (wr_evcnt && (sel_q == 5'(g))),
      .wr_type (wr_evtype && (sel_q == 5'(g))),
      .wdata   (reg_wdata),
      .count_q (evt_count[g]),
      .type_q  (evt_type[g]),
      .wrap    (evt_wrap[g])
    );
  end

  pmu_cycle_counter #(.PRESCALE(PRESCALE)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[0] && cnt_en_q[CYC_BIT]),
    .div_en  (ctrl_q[3]),
    .clr     (wr_ctrl && reg_wdata[2]),
    .wr_cnt  (wr_cyc),
    .wdata   (reg_wdata),
    .count_q (cyc_count),
    .wrap    (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = evt_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_en_q <= '0;
      irq_en_q <= '0;
      ovf_q    <= '0;
      sel_q    <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= reg_wdata[5:0] & CTRL_KEEP;
      if (wr_en_set) cnt_en_q <= cnt_en_q | (reg_wdata & IMPL_MASK);
      if (wr_en_clr) cnt_en_q <= cnt_en_q & ~reg_wdata;
      if (wr_ie_set) irq_en_q <= irq_en_q | (reg_wdata & IMPL_MASK);
      if (wr_ie_clr) irq_en_q <= irq_en_q & ~reg_wdata;
      if (wr_sel)    sel_q    <= reg_wdata[4:0];
      ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata : 32'h0)) | wrap_vec;
    end
  end

  logic [31:0] sel_count, sel_type;
  always_comb begin
    sel_count = '0;
    sel_type  = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (sel_q == 5'(i)) begin
        sel_count = evt_count[i];
        sel_type  = evt_type[i];
      end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:             reg_rdata = {16'h0, 5'(NUM_CNT), 5'h0, ctrl_q};
      A_EN_SET, A_EN_CLR: reg_rdata = cnt_en_q;
      A_IE_SET, A_IE_CLR: reg_rdata = irq_en_q;
      A_OVF:              reg_rdata = ovf_q;
      A_SEL:              reg_rdata = {27'h0, sel_q};
      A_EVCNT:            reg_rdata = sel_count;
      A_EVTYPE:           reg_rdata = sel_type;
      A_CYCCNT:           reg_rdata = cyc_count;
      default:            reg_rdata = 32'h0;
    endcase
  end

  assign irq = |(ovf_q & irq_en_q);

  a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
  a_r5_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_set && !wr_en_clr) |=> ((cnt_en_q & $past(cnt_en_q)) == $past(cnt_en_q)));
  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != 32'h0 && irq_en_q != 32'h0));
endmodule

// File: tb/test_pmu_counter_unit.sv
module test_pmu_counter_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_bus = 32'h0;
  logic [1:0]  el = 2'd0;
  logic        irq;

  int total = 0;
  int fails = 0;

  pmu_counter_unit #(.NUM_CNT(N), .NUM_EVENTS(32), .PRESCALE(64)) i_pmu_counter_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus),
    .el(el), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] m, input int n);
    for (int i = 0; i < n; i++) begin evt_bus = m; @(negedge clk); end
    evt_bus = 32'h0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd0, v);  check("R1 control at reset", v, 32'h0000_2000);
    rd(4'd1, v);  check("R1 enables at reset", v, 32'h0);
    rd(4'd5, v);  check("R1 flags at reset", v, 32'h0);
    rd(4'd9, v);  check("R1 cycle count at reset", v, 32'h0);
    check("R1 irq at reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF & 32'h3F);
    rd(4'd0, v);  check("R2 control readback", v, 32'h0000_2039);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v);  check("R5 set all, unimplemented bits zero", v, 32'h8000_000F);
    wr(4'd2, 32'h0000_0005);
    rd(4'd2, v);  check("R5 clear selected bits", v, 32'h8000_000A);
    wr(4'd1, 32'h0);
    rd(4'd1, v);  check("R5 zero write has no effect", v, 32'h8000_000A);
    wr(4'd3, 32'h0000_0002);
    rd(4'd4, v);  check("R5 interrupt enable set", v, 32'h0000_0002);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd3, v);  check("R5 interrupt enable clear", v, 32'h0);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_cycle;
    logic [31:0] v;
    wr(4'd0, 32'h05);
    repeat (10) @(negedge clk);
    rd(4'd9, v);  check("R4 full-rate cycle count", v, 32'd10);
    wr(4'd0, 32'h0D);
    repeat (63) @(negedge clk);
    rd(4'd9, v);  check("R4 divided count before tick", v, 32'd0);
    @(negedge clk);
    rd(4'd9, v);  check("R4 divided count after 64", v, 32'd1);
    wr(4'd0, 32'h04);
    rd(4'd9, v);  check("R3 cycle reset", v, 32'd0);
    repeat (5) @(negedge clk);
    rd(4'd9, v);  check("R4 no count while disabled", v, 32'd0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    wr(4'd6, 32'd0); wr(4'd8, 32'h3);
    wr(4'd6, 32'd2); wr(4'd8, 32'h4);
    wr(4'd0, 32'h03);
    pulse(32'h8, 5);
    pulse(32'h10, 3);
    pulse(32'h18, 2);
    wr(4'd6, 32'd0); rd(4'd7, v); check("R8 counter 0 on event 3", v, 32'd7);
    wr(4'd6, 32'd2); rd(4'd7, v); check("R6 R8 counter 2 on event 4", v, 32'd5);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v);  check("R7 type write mask", v, 32'hC800_03FF);
    wr(4'd8, 32'h4);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    wr(4'd6, 32'd0); wr(4'd8, 32'h8000_0003);
    wr(4'd0, 32'h03);
    el = 2'd1; pulse(32'h8, 4);
    rd(4'd7, v);  check("R9 level 1 blocked", v, 32'd0);
    el = 2'd0; pulse(32'h8, 2);
    rd(4'd7, v);  check("R9 level 0 counts", v, 32'd2);
    wr(4'd8, 32'h4000_0003);
    pulse(32'h8, 3);
    el = 2'd2; pulse(32'h8, 2);
    rd(4'd7, v);  check("R9 level 0 blocked and level 2 off", v, 32'd2);
    wr(4'd8, 32'h0800_0003);
    pulse(32'h8, 3);
    el = 2'd3; pulse(32'h8, 1);
    rd(4'd7, v);  check("R9 level 2 on and level 3 counts", v, 32'd6);
    el = 2'd0;
  endtask

  task automatic t_cycle_event;
    logic [31:0] a, b;
    wr(4'd6, 32'd1); wr(4'd8, 32'h11);
    rd(4'd7, a);
    repeat (7) @(negedge clk);
    rd(4'd7, b);  check("R8 event 0x11 counts every clock", b - a, 32'd7);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(4'd6, 32'd0); wr(4'd7, 32'h1234);
    wr(4'd6, N);     wr(4'd7, 32'hDEAD);
    rd(4'd7, v);  check("R6 out-of-range select reads zero", v, 32'h0);
    wr(4'd8, 32'h3);
    rd(4'd8, v);  check("R6 out-of-range type reads zero", v, 32'h0);
    wr(4'd6, 32'd0); rd(4'd7, v); check("R6 counter 0 untouched", v, 32'h1234);
    wr(4'd6, 32'd3); rd(4'd7, v); check("R6 counter 3 untouched", v, 32'h0);
  endtask

  task automatic t_swinc;
    logic [31:0] v;
    wr(4'd6, 32'd3); wr(4'd8, 32'h0); wr(4'd7, 32'h0);
    wr(4'd10, 32'h8);
    wr(4'd10, 32'h8);
    rd(4'd7, v);  check("R10 software increment", v, 32'd2);
    wr(4'd6, 32'd0); wr(4'd7, 32'h50);
    wr(4'd10, 32'h1);
    rd(4'd7, v);  check("R10 ignored for other event", v, 32'h50);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(4'd7, 32'hFFFF_FFFE);
    pulse(32'h8, 2);
    rd(4'd7, v);  check("R11 wrapped to zero", v, 32'h0);
    rd(4'd5, v);  check("R11 flag 0 set", v & 32'h1, 32'h1);
    check("R12 irq low without enable", {31'h0, irq}, 32'h0);
    wr(4'd3, 32'h1);
    check("R12 irq with enable", {31'h0, irq}, 32'h1);
    wr(4'd5, 32'h0);
    rd(4'd5, v);  check("R11 zero write keeps flag", v & 32'h1, 32'h1);
    wr(4'd5, 32'h1);
    rd(4'd5, v);  check("R11 clear flag 0", v & 32'h1, 32'h0);
    check("R12 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(4'd0, 32'h01);
    wr(4'd9, 32'hFFFF_FFF0);
    repeat (20) @(negedge clk);
    rd(4'd5, v);  check("R11 cycle overflow on bit 31", v & 32'h8000_0000, 32'h8000_0000);
    check("R12 irq low for unenabled bit 31", {31'h0, irq}, 32'h0);
    wr(4'd3, 32'h8000_0000);
    check("R12 irq for bit 31", {31'h0, irq}, 32'h1);
    wr(4'd5, 32'h8000_0000);
    check("R12 irq after cycle flag clear", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_enables();
    t_cycle();
    t_events();
    t_filter();
    t_cycle_event();
    t_select();
    t_swinc();
    t_overflow();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule